// File: doc/BRIEF.md
# Electronic Shutter Exposure Controller

This block sets the exposure time of an interline CCD camera. It places a single substrate shutter pulse inside the line-by-line readout of a frame. At the start of each frame the readout sequencer pulses `frame_go`, and the block latches the requested exposure length `exp_lines`, counted in lines. The sequencer then reports the end of every line on `line_end`, at the moment the last pixel has left the horizontal register and that register is empty.

When `NV_LINES - exp_lines` lines have finished, the block raises `vhold`, which freezes the vertical clocks. It waits a guard interval and then drives `shutter` high for a fixed width. After a second guard interval it releases the hold. The remaining `exp_lines` lines then run, and `xfer_due` tells the sequencer to start the frame transfer that ends the exposure.

Exposure starts on the falling edge of the shutter pulse. If no shutter fires, the exposure equals the whole frame readout. The pulse is suppressed while the power-stable flag `pwr_ok` is low, and also when the requested length is zero or does not fit in the frame. The widths are counted in clock cycles: `GUARD_CYC` and `FIRE_CYC` correspond to roughly one microsecond each.

Top module: `shx_exposure_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `shutter`, `vhold` and `xfer_due` are all low.
- R2: `xfer_due` is a one-cycle pulse. It rises in the cycle after the `NV_LINES`-th accepted `line_end` of a frame, and it fires exactly once per frame.
- R3: With a valid exposure length N, `vhold` rises in the cycle after the (`NV_LINES` − N)-th accepted `line_end`, and `shutter` rises exactly `GUARD_CYC` cycles after `vhold`.
- R4: `shutter` stays high for exactly `FIRE_CYC` cycles.
- R5: After `shutter` falls, `vhold` stays high for exactly `GUARD_CYC` more cycles and then drops.
- R6: The interval from the falling edge of `shutter` to the rise of `xfer_due` is `GUARD_CYC` plus the time taken by the N lines that follow the hold.
- R7: An exposure length of 0, or of `NV_LINES` or more, produces no shutter pulse and no hold for that whole frame.
- R8: If `pwr_ok` is low in the cycle in which the trigger line ends, no hold and no shutter pulse occur in that frame.
- R9: `exp_lines` is sampled only on an accepted `frame_go`. A change during a frame takes effect on the next frame.
- R10: The block ignores `frame_go` while a frame is running. It ignores `line_end` while no frame is running and while `vhold` is high. Ignored pulses do not change the line count.
- R11: `shutter` is high only while `vhold` is high, so every shutter transition lies inside the hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Start-of-frame pulse; latches the exposure length |
| line_end | input | 1 | End-of-line pulse, asserted when the horizontal register is empty |
| exp_lines | input | $clog2(NV_LINES+1) | Requested exposure length in lines |
| pwr_ok | input | 1 | Power-stable flag; a low level blocks the shutter |
| shutter | output | 1 | Shutter pulse bit for the substrate driver |
| vhold | output | 1 | Stall request for the vertical clocks |
| xfer_due | output | 1 | One-cycle pulse: all lines done, start the frame transfer |

## Verification
The bench builds the block with `NV_LINES`=12, `GUARD_CYC`=3 and `FIRE_CYC`=4, and drives lines with a fixed period of 10 cycles. These sizes keep a frame to about 150 cycles, so many complete frames fit in one run. They also bring the edge cases within reach: an exposure length of 1, of `NV_LINES`−1, of exactly `NV_LINES`, and a value above `NV_LINES`. With a short guard and a short pulse, each edge of the hold window can be checked cycle by cycle.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_FIRE = 2'd2,
    PH_POST = 2'd3
  } shx_phase_t;

  // A shutter is wanted only when the exposure fits strictly inside the frame.
  function automatic logic shot_wanted(input int nexp, input int nv);
    return (nexp != 0) && (nexp < nv);
  endfunction

  // Line count after which the shutter is inserted.
  function automatic int fire_line(input int nexp, input int nv);
    return nv - nexp;
  endfunction

endpackage

// File: rtl/shx_line_ctr.sv
module shx_line_ctr #(
  parameter int NV_LINES = 5392,
  localparam int LW = $clog2(NV_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  input  logic          line_end,
  input  logic          stall,
  input  logic [LW-1:0] exp_lines,
  output logic          fire_req,
  output logic          xfer_due
);
  import shx_pkg::*;

  logic [LW-1:0] cnt_q, nexp_q, cnt_nx, trig_line;
  logic          run_q, shot_q, due_q;
  logic          accept, last_line;

  assign accept    = run_q && line_end && !stall;
  assign cnt_nx    = cnt_q + 1'b1;
  assign last_line = (cnt_nx == LW'(NV_LINES));
  assign trig_line = LW'(fire_line(int'(nexp_q), NV_LINES));
  assign fire_req  = accept && shot_q && (cnt_nx == trig_line);
  assign xfer_due  = due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nexp_q <= '0;
      run_q  <= 1'b0;
      shot_q <= 1'b0;
      due_q  <= 1'b0;
    end else begin
      due_q <= 1'b0;
      if (!run_q) begin
        if (frame_go) begin
          run_q  <= 1'b1;
          cnt_q  <= '0;
          nexp_q <= exp_lines;
          shot_q <= shot_wanted(int'(exp_lines), NV_LINES);
        end
      end else if (accept) begin
        cnt_q <= cnt_nx;
        if (last_line) begin
          run_q <= 1'b0;
          due_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/shx_pulse_seq.sv
module shx_pulse_seq #(
  parameter int GUARD_CYC = 40,
  parameter int FIRE_CYC  = 40,
  localparam int MAXC = (GUARD_CYC > FIRE_CYC) ? GUARD_CYC : FIRE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic shutter,
  output logic vhold
);
  import shx_pkg::*;

  shx_phase_t    ph_q;
  logic [CW-1:0] cnt_q, lim;
  logic          done;

  always_comb begin
    lim  = (ph_q == PH_FIRE) ? CW'(FIRE_CYC - 1) : CW'(GUARD_CYC - 1);
    done = (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start) ph_q <= PH_PRE;
        end
        PH_PRE: begin
          if (done) begin ph_q <= PH_FIRE; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_FIRE: begin
          if (done) begin ph_q <= PH_POST; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (done) begin ph_q <= PH_IDLE; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign shutter = (ph_q == PH_FIRE);
  assign vhold   = (ph_q != PH_IDLE);

endmodule

// File: rtl/shx_exposure_ctl.sv
module shx_exposure_ctl #(
  parameter int NV_LINES  = 5392,
  parameter int GUARD_CYC = 40,
  parameter int FIRE_CYC  = 40,
  localparam int LW = $clog2(NV_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  input  logic          line_end,
  input  logic [LW-1:0] exp_lines,
  input  logic          pwr_ok,
  output logic          shutter,
  output logic          vhold,
  output logic          xfer_due
);

  logic boundary_hit;
  logic fire_start;

  assign fire_start = boundary_hit && pwr_ok;

  shx_line_ctr #(.NV_LINES(NV_LINES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .line_end (line_end),
    .stall    (vhold),
    .exp_lines(exp_lines),
    .fire_req (boundary_hit),
    .xfer_due (xfer_due)
  );

  shx_pulse_seq #(.GUARD_CYC(GUARD_CYC), .FIRE_CYC(FIRE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (fire_start),
    .shutter(shutter),
    .vhold  (vhold)
  );

endmodule

// File: rtl/shx_exposure_chk.sv
module shx_exposure_chk #(
  parameter int GUARD_CYC = 40,
  parameter int FIRE_CYC  = 40
) (
  input logic clk,
  input logic rst_n,
  input logic line_end,
  input logic pwr_ok,
  input logic shutter,
  input logic vhold,
  input logic xfer_due
);
  int hold_run, fire_run, post_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_run <= 0;
      fire_run <= 0;
      post_run <= 0;
    end else begin
      hold_run <= vhold ? hold_run + 1 : 0;
      fire_run <= shutter ? fire_run + 1 : 0;
      post_run <= shutter ? 0 : (vhold ? post_run + 1 : 0);
    end
  end

  // R11
  shutter_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> vhold);

  // R3
  pre_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter) |-> hold_run == GUARD_CYC);

  // R4
  fire_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutter) |-> fire_run == FIRE_CYC);

  // R5
  post_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vhold) |-> post_run == GUARD_CYC);

  // R2
  due_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_due |=> !xfer_due);

  // R8
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vhold) |-> $past(pwr_ok) && $past(line_end));

  // R10
  due_outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_due |-> !vhold);

endmodule

bind shx_exposure_ctl shx_exposure_chk #(
  .GUARD_CYC(GUARD_CYC),
  .FIRE_CYC (FIRE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .line_end(line_end),
  .pwr_ok  (pwr_ok),
  .shutter (shutter),
  .vhold   (vhold),
  .xfer_due(xfer_due)
);

// File: tb/tb_shx_exposure_ctl.sv
module tb_shx_exposure_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 12;
  localparam int G    = 3;
  localparam int P    = 4;
  localparam int LINE = 10;
  localparam int PD   = 5;
  localparam int LW   = $clog2(NV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_go = 1'b0, line_end = 1'b0, pwr_ok = 1'b0, pd = 1'b0;
  logic [LW-1:0] exp_lines = '0;
  logic shutter, vhold, xfer_due;

  int checks = 0, fails = 0, cyc = 0;
  int sh_rise, sh_fall, vh_rise, vh_fall, n_sh, n_vh, n_xd;
  logic sh_p = 1'b0, vh_p = 1'b0;
  int issued, trig_cyc, pd_fall;
  bit got;

  shx_exposure_ctl #(.NV_LINES(NV), .GUARD_CYC(G), .FIRE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .line_end(line_end),
    .exp_lines(exp_lines), .pwr_ok(pwr_ok),
    .shutter(shutter), .vhold(vhold), .xfer_due(xfer_due)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (shutter && !sh_p) begin sh_rise = cyc; n_sh++; end
    if (!shutter && sh_p) sh_fall = cyc;
    if (vhold && !vh_p) begin vh_rise = cyc; n_vh++; end
    if (!vhold && vh_p) vh_fall = cyc;
    if (xfer_due) n_xd++;
    sh_p = shutter;
    vh_p = vhold;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nexp, input bit pwr, input int alt_exp,
                           input bit mid_go, input bit poke, input int idle_ends);
    @(negedge clk);
    n_sh = 0; n_vh = 0; n_xd = 0; issued = 0; trig_cyc = -1; got = 0;
    sh_rise = -1; sh_fall = -1; vh_rise = -1; vh_fall = -1; pd_fall = -1;
    repeat (idle_ends) begin
      line_end = 1'b1; @(negedge clk); line_end = 1'b0; @(negedge clk);
    end
    exp_lines = LW'(nexp); pwr_ok = pwr; frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0; exp_lines = LW'(alt_exp);
    for (int li = 0; li < NV + 2 && !got; li++) begin
      if (mid_go && li == 2) begin
        frame_go = 1'b1; @(negedge clk); frame_go = 1'b0;
        repeat (LINE - 2) @(negedge clk);
      end else begin
        repeat (LINE - 1) @(negedge clk);
      end
      line_end = 1'b1; @(negedge clk); line_end = 1'b0;
      issued++;
      if (issued == NV - nexp) trig_cyc = cyc;
      if (vhold) begin
        if (poke) begin line_end = 1'b1; @(negedge clk); line_end = 1'b0; end
        while (vhold) @(negedge clk);
      end
      if (xfer_due) begin
        got = 1;
        pd = 1'b1; repeat (PD) @(negedge clk); pd = 1'b0;
        pd_fall = cyc;
      end
    end
    @(negedge clk);
  endtask

  task automatic check_shot(input int nexp);
    chk("R3 one hold", n_vh, 1);
    chk("R3 hold after trigger line", vh_rise, trig_cyc);
    chk("R3 pre-guard", sh_rise - vh_rise, G);
    chk("R4 pulse width", sh_fall - sh_rise, P);
    chk("R5 post-guard", vh_fall - sh_fall, G);
    chk("R6 exposure to transfer fall", pd_fall - sh_fall, G + nexp * LINE + PD);
    chk("R2 frame ends after NV lines", issued, NV);
    chk("R2 single due pulse", n_xd, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 shutter in reset", int'(shutter), 0);
    chk("R1 vhold in reset", int'(vhold), 0);
    chk("R1 xfer_due in reset", int'(xfer_due), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", int'({shutter, vhold, xfer_due}), 0);
  endtask

  task automatic t_basic();
    run_frame(3, 1'b1, 3, 1'b0, 1'b0, 0);
    check_shot(3);
    chk("R11 shutter inside hold",
        int'(sh_rise > vh_rise && sh_fall < vh_fall), 1);
  endtask

  task automatic t_edges();
    run_frame(1, 1'b1, 1, 1'b0, 1'b0, 0);
    check_shot(1);
    run_frame(NV - 1, 1'b1, NV - 1, 1'b0, 1'b0, 0);
    check_shot(NV - 1);
  endtask

  task automatic t_suppress();
    int vals[3] = '{0, NV, 15};
    foreach (vals[i]) begin
      run_frame(vals[i], 1'b1, vals[i], 1'b0, 1'b0, 0);
      chk("R7 no shutter", n_sh, 0);
      chk("R7 no hold", n_vh, 0);
      chk("R7 full frame of lines", issued, NV);
    end
  endtask

  task automatic t_power();
    run_frame(4, 1'b0, 4, 1'b0, 1'b0, 0);
    chk("R8 no shutter without power", n_sh, 0);
    chk("R8 no hold without power", n_vh, 0);
    run_frame(4, 1'b1, 4, 1'b0, 1'b0, 0);
    chk("R8 shutter with power", n_sh, 1);
  endtask

  task automatic t_latch();
    run_frame(5, 1'b1, 2, 1'b1, 1'b0, 0);
    chk("R9 latched length used", pd_fall - sh_fall, G + 5 * LINE + PD);
    chk("R10 mid-frame go ignored", issued, NV);
    run_frame(2, 1'b1, 2, 1'b0, 1'b0, 0);
    chk("R9 new length next frame", pd_fall - sh_fall, G + 2 * LINE + PD);
  endtask

  task automatic t_ignore();
    run_frame(3, 1'b1, 3, 1'b0, 1'b1, 3);
    chk("R10 idle and held line ends ignored", issued, NV);
    check_shot(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_edges();
    t_suppress();
    t_power();
    t_latch();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule